// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block fetches one instruction of variable length from a storage array that delivers one six-bit character per access, each with a word-mark flag. After a start request it walks a ring counter from the op position through positions 1 to 12. It presents the fetch address to storage and advances that address by one for every character it accepts. Each character goes to the op register, one of two five-character address registers, a three-character I/O control register, or the modifier register, depending on the op class and the ring position.

The end of an instruction is only known when a character carrying a word mark arrives, because that mark belongs to the next instruction. The count of characters read up to that point is the instruction length. It is checked against the set of lengths the op code allows, and no set contains two lengths one apart. On a good fetch the block pulses `done`, reports the length, and gives the next instruction address, which is the position of the terminating word mark. A missing op word mark, an illegal length or a run past position 12 ends the fetch with an error flag instead.

Top module: `instr_fetch_seq`

## Requirements
- R1: After reset `rd_en`, `done`, `err_op`, `err_len` are 0 and `op_code`, `a_addr`, `b_addr`, `io_ctl`, `modifier`, `instr_len`, `next_addr` are all zero.
- R2: A `start` while idle loads `rd_addr` with `start_addr`, raises `rd_en`, puts the ring at the op position, and clears all field registers, `instr_len` and both error flags. A `start` while a fetch is in progress has no effect on the address sequence or the result.
- R3: The character accepted at the op position must carry a word mark. If it does, it is loaded into `op_code`. If it does not, the fetch ends with `err_op`=1 and a `done` pulse, and `rd_addr` stays at the start address.
- R4: `rd_addr` advances by one for every accepted character that does not end the fetch. It holds in any cycle where `ch_valid` is 0. At the end of a fetch it points at the last character read.
- R5: Op classes by character code (hex): 31 and 12 are arithmetic with legal lengths {1,6,11}; 32 and 24 are modifier ops with legal lengths {2,7,12}; 29 is I/O with legal lengths {5,10}; every other code has no legal length.
- R6: For arithmetic and modifier classes, ring positions 1 to 5 shift into `a_addr` and positions 6 to 10 shift into `b_addr`, regardless of the final length. Each new character enters bits [5:0] and earlier ones move up, so position 1 ends in bits [29:24].
- R7: For the I/O class, positions 1 to 3 shift into `io_ctl` the same way (position 1 ends in bits [17:12]) and positions 4 to 8 shift into `a_addr`.
- R8: On a successful fetch of the modifier or I/O class, `modifier` takes the last character before the terminating word mark. For the arithmetic class it stays 0.
- R9: A word mark at ring position p ≥ 1 ends the fetch with `instr_len` = p. If p is not a legal length for the op, `err_len`=1 and `next_addr` keeps its previous value.
- R10: A character without a word mark at position 12 ends the fetch with `err_len`=1 and `instr_len`=0.
- R11: A successful fetch pulses `done` for exactly one cycle, with `err_op`=`err_len`=0, `instr_len` equal to the character count, and `next_addr` equal to the address of the terminating word-mark character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| start_addr | input | 16 | Address of the op character |
| ch_data | input | 6 | Character returned from storage for `rd_addr` |
| ch_wm | input | 1 | Word-mark flag of that character |
| ch_valid | input | 1 | Character present this cycle |
| rd_addr | output | 16 | Current fetch address |
| rd_en | output | 1 | Fetch in progress |
| op_code | output | 6 | Op register |
| a_addr | output | 30 | First address register, five characters |
| b_addr | output | 30 | Second address register, five characters |
| io_ctl | output | 18 | I/O control field, three characters |
| modifier | output | 6 | Modifier register |
| instr_len | output | 4 | Characters counted up to the terminating word mark |
| next_addr | output | 16 | Address of the next instruction |
| done | output | 1 | One-cycle end-of-fetch pulse |
| err_op | output | 1 | Op character lacked its word mark |
| err_len | output | 1 | Length illegal for the op, or no terminator by position 12 |

## Verification
The assertions assume that storage asserts `ch_valid` only while `rd_en` is high, and that `ch_data` and `ch_wm` belong to the address shown on `rd_addr` in that same cycle. The bench's storage model keeps to this. On each falling edge it reads its array at `rd_addr` and gates `ch_valid` with `rd_en`. It stretches the character stream with idle cycles on alternate runs, so both the back-to-back and the stalled address-advance paths are driven. A stray `start` is only issued in the middle of a fetch, where it must be ignored.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  localparam int CHAR_W = 6;

  // character codes of the recognised op codes
  localparam logic [CHAR_W-1:0] OPC_ADD  = 6'h31;
  localparam logic [CHAR_W-1:0] OPC_SUB  = 6'h12;
  localparam logic [CHAR_W-1:0] OPC_BRA  = 6'h32;
  localparam logic [CHAR_W-1:0] OPC_MOVE = 6'h24;
  localparam logic [CHAR_W-1:0] OPC_IO   = 6'h29;

  typedef enum logic [1:0] {
    CL_BAD   = 2'd0,
    CL_ARITH = 2'd1,
    CL_MODOP = 2'd2,
    CL_IO    = 2'd3
  } op_class_e;

  function automatic op_class_e op_class(input logic [CHAR_W-1:0] opc);
    case (opc)
      OPC_ADD, OPC_SUB:  return CL_ARITH;
      OPC_BRA, OPC_MOVE: return CL_MODOP;
      OPC_IO:            return CL_IO;
      default:           return CL_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ifs_ring.sv
module ifs_ring
  import ifs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ADDR_CHARS = 5,
  parameter int CTL_CHARS  = 3,
  parameter int PW         = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              ch_valid,
  input  logic              ch_wm,
  input  op_class_e         cls,
  output logic [PW-1:0]     pos,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              err_op,
  output logic              err_len,
  output logic [PW-1:0]     len,
  output logic [ADDR_W-1:0] next_addr,
  output logic              clr,
  output logic              ld_op,
  output logic              ld_body,
  output logic              fin_mod
);

  localparam int RING_MAX = 2*ADDR_CHARS + 2;
  localparam logic [PW-1:0] P_END = PW'(RING_MAX);

  logic [PW-1:0]     pos_q, len_q;
  logic              busy_q, done_q, err_op_q, err_len_q;
  logic [ADDR_W-1:0] addr_q, next_q;
  logic [(1<<PW)-1:0] legal_mask;
  logic              take, at_op, at_end, legal, good_end;

  // legal lengths per class; no set holds two adjacent lengths
  always_comb begin
    legal_mask = '0;
    case (cls)
      CL_ARITH: begin
        legal_mask[1]              = 1'b1;
        legal_mask[1+ADDR_CHARS]   = 1'b1;
        legal_mask[1+2*ADDR_CHARS] = 1'b1;
      end
      CL_MODOP: begin
        legal_mask[2]              = 1'b1;
        legal_mask[2+ADDR_CHARS]   = 1'b1;
        legal_mask[2+2*ADDR_CHARS] = 1'b1;
      end
      CL_IO: begin
        legal_mask[2+CTL_CHARS]            = 1'b1;
        legal_mask[2+CTL_CHARS+ADDR_CHARS] = 1'b1;
      end
      default: ;
    endcase
  end

  assign take     = busy_q & ch_valid;
  assign at_op    = (pos_q == '0);
  assign at_end   = (pos_q == P_END);
  assign legal    = legal_mask[pos_q];
  assign good_end = take & ~at_op & ch_wm & legal;

  assign clr     = ~busy_q & start;
  assign ld_op   = take & at_op & ch_wm;
  assign ld_body = take & ~at_op & ~ch_wm & ~at_end;
  assign fin_mod = good_end & ((cls == CL_MODOP) | (cls == CL_IO));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      len_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_op_q  <= 1'b0;
      err_len_q <= 1'b0;
      addr_q    <= '0;
      next_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q    <= 1'b1;
          pos_q     <= '0;
          addr_q    <= start_addr;
          len_q     <= '0;
          err_op_q  <= 1'b0;
          err_len_q <= 1'b0;
        end
      end else if (ch_valid) begin
        if (at_op) begin
          if (!ch_wm) begin
            err_op_q <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            pos_q  <= pos_q + 1'b1;
            addr_q <= addr_q + 1'b1;
          end
        end else if (ch_wm) begin
          len_q  <= pos_q;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (legal) next_q <= addr_q;
          else       err_len_q <= 1'b1;
        end else if (at_end) begin
          err_len_q <= 1'b1;
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
        end else begin
          pos_q  <= pos_q + 1'b1;
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign pos       = pos_q;
  assign busy      = busy_q;
  assign rd_addr   = addr_q;
  assign done      = done_q;
  assign err_op    = err_op_q;
  assign err_len   = err_len_q;
  assign len       = len_q;
  assign next_addr = next_q;

  p_ring_bound_r10: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (pos_q <= P_END));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    ld_body |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ch_valid) |=> $stable(addr_q));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start) |=> $stable(addr_q));

  p_err_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(err_op_q && err_len_q));

  p_err_ends_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_len_q) |-> (done_q && !busy_q));

endmodule

// File: rtl/ifs_regs.sv
module ifs_regs
  import ifs_pkg::*;
#(
  parameter int ADDR_CHARS = 5,
  parameter int CTL_CHARS  = 3,
  parameter int PW         = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         ld_op,
  input  logic                         ld_body,
  input  logic                         fin_mod,
  input  logic                         is_io,
  input  logic [PW-1:0]                pos,
  input  logic [CHAR_W-1:0]            ch,
  output logic [CHAR_W-1:0]            op_q,
  output logic [ADDR_CHARS*CHAR_W-1:0] a_q,
  output logic [ADDR_CHARS*CHAR_W-1:0] b_q,
  output logic [CTL_CHARS*CHAR_W-1:0]  ctl_q,
  output logic [CHAR_W-1:0]            mod_q
);

  localparam int AW = ADDR_CHARS*CHAR_W;
  localparam int TW = CTL_CHARS*CHAR_W;
  localparam logic [PW-1:0] P_A_LO  = PW'(1);
  localparam logic [PW-1:0] P_A_HI  = PW'(ADDR_CHARS);
  localparam logic [PW-1:0] P_B_HI  = PW'(2*ADDR_CHARS);
  localparam logic [PW-1:0] P_T_HI  = PW'(CTL_CHARS);
  localparam logic [PW-1:0] P_IA_HI = PW'(CTL_CHARS + ADDR_CHARS);

  logic [CHAR_W-1:0] last_q;
  logic sel_a, sel_b, sel_t;

  // steering by class and ring position, high-order character first
  always_comb begin
    if (is_io) begin
      sel_t = (pos >= P_A_LO) && (pos <= P_T_HI);
      sel_a = (pos >  P_T_HI) && (pos <= P_IA_HI);
      sel_b = 1'b0;
    end else begin
      sel_t = 1'b0;
      sel_a = (pos >= P_A_LO) && (pos <= P_A_HI);
      sel_b = (pos >  P_A_HI) && (pos <= P_B_HI);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      ctl_q  <= '0;
      mod_q  <= '0;
      last_q <= '0;
    end else begin
      if (ld_op) op_q <= ch;
      if (ld_body) begin
        last_q <= ch;
        if (sel_a) a_q   <= {a_q[AW-CHAR_W-1:0], ch};
        if (sel_b) b_q   <= {b_q[AW-CHAR_W-1:0], ch};
        if (sel_t) ctl_q <= {ctl_q[TW-CHAR_W-1:0], ch};
      end
      if (fin_mod) mod_q <= last_q;
    end
  end

  p_op_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ld_body |=> $stable(op_q));

  p_mod_final_r8: assert property (@(posedge clk) disable iff (rst)
    ld_body |=> $stable(mod_q));

  p_io_no_b_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_body && is_io) |=> $stable(b_q));

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
  import ifs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ADDR_CHARS = 5,
  parameter int CTL_CHARS  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            start_addr,
  input  logic [CHAR_W-1:0]            ch_data,
  input  logic                         ch_wm,
  input  logic                         ch_valid,
  output logic [ADDR_W-1:0]            rd_addr,
  output logic                         rd_en,
  output logic [CHAR_W-1:0]            op_code,
  output logic [ADDR_CHARS*CHAR_W-1:0] a_addr,
  output logic [ADDR_CHARS*CHAR_W-1:0] b_addr,
  output logic [CTL_CHARS*CHAR_W-1:0]  io_ctl,
  output logic [CHAR_W-1:0]            modifier,
  output logic [$clog2(2*ADDR_CHARS+3)-1:0] instr_len,
  output logic [ADDR_W-1:0]            next_addr,
  output logic                         done,
  output logic                         err_op,
  output logic                         err_len
);

  localparam int RING_MAX = 2*ADDR_CHARS + 2;
  localparam int PW       = $clog2(RING_MAX + 1);

  logic [PW-1:0] pos;
  logic          clr, ld_op, ld_body, fin_mod;
  op_class_e     cls;

  assign cls = op_class(op_code);

  ifs_ring #(
    .ADDR_W(ADDR_W), .ADDR_CHARS(ADDR_CHARS), .CTL_CHARS(CTL_CHARS), .PW(PW)
  ) ring_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .ch_valid(ch_valid), .ch_wm(ch_wm), .cls(cls),
    .pos(pos), .busy(rd_en), .rd_addr(rd_addr), .done(done),
    .err_op(err_op), .err_len(err_len), .len(instr_len),
    .next_addr(next_addr), .clr(clr), .ld_op(ld_op),
    .ld_body(ld_body), .fin_mod(fin_mod)
  );

  ifs_regs #(
    .ADDR_CHARS(ADDR_CHARS), .CTL_CHARS(CTL_CHARS), .PW(PW)
  ) regs_i (
    .clk(clk), .rst(rst), .clr(clr), .ld_op(ld_op), .ld_body(ld_body),
    .fin_mod(fin_mod), .is_io(cls == CL_IO), .pos(pos), .ch(ch_data),
    .op_q(op_code), .a_q(a_addr), .b_q(b_addr), .ctl_q(io_ctl),
    .mod_q(modifier)
  );

endmodule

// File: tb/instr_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module instr_fetch_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [5:0]  ch_data = '0;
  logic        ch_wm = 1'b0;
  logic        ch_valid = 1'b0;
  logic [15:0] rd_addr, next_addr;
  logic        rd_en, done, err_op, err_len;
  logic [5:0]  op_code, modifier;
  logic [29:0] a_addr, b_addr;
  logic [17:0] io_ctl;
  logic [3:0]  instr_len;

  instr_fetch_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .ch_data(ch_data), .ch_wm(ch_wm), .ch_valid(ch_valid),
    .rd_addr(rd_addr), .rd_en(rd_en), .op_code(op_code),
    .a_addr(a_addr), .b_addr(b_addr), .io_ctl(io_ctl),
    .modifier(modifier), .instr_len(instr_len), .next_addr(next_addr),
    .done(done), .err_op(err_op), .err_len(err_len)
  );

  always #2 clk = ~clk;

  logic [5:0] mem_c [256];
  logic       mem_w [256];
  int  gcnt = 0;
  int  checks = 0;
  int  errors = 0;
  bit  gap_mode = 1'b0;
  logic [15:0] exp_next = '0;

  // storage model: answers the presented address, optionally with stalls
  always @(negedge clk) begin
    gcnt++;
    ch_valid = rd_en && !(gap_mode && (gcnt % 3 == 0));
    ch_data  = mem_c[rd_addr[7:0]];
    ch_wm    = mem_w[rd_addr[7:0]];
    if (gcnt > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<150000", gcnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int cls_of(input logic [5:0] opc);
    if (opc == 6'h31 || opc == 6'h12) return 1;
    if (opc == 6'h32 || opc == 6'h24) return 2;
    if (opc == 6'h29) return 3;
    return 0;
  endfunction

  function automatic bit len_ok(input int c, input int l);
    case (c)
      1: return (l == 1) || (l == 6) || (l == 11);
      2: return (l == 2) || (l == 7) || (l == 12);
      3: return (l == 5) || (l == 10);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [5:0] body_ch(input int seed, input int i);
    return 6'((seed * 5 + i * 11 + 3) & 63);
  endfunction

  // n_wm: position of the terminating word mark (13 = none through 12)
  task automatic run(input logic [5:0] opc, input bit op_wm, input int n_wm,
                     input int seed, input int base, input bit inject);
    int c, k, lim;
    bit ok_len;
    logic [29:0] ea, eb;
    logic [17:0] et;
    logic [5:0]  em;
    logic [15:0] erd;
    logic [3:0]  elen;
    c   = cls_of(opc);
    lim = (n_wm > 12) ? 12 : n_wm;
    for (int i = 0; i <= lim; i++) begin
      mem_c[base + i] = (i == 0) ? opc : body_ch(seed, i);
      mem_w[base + i] = (i == 0) ? op_wm : (i == n_wm);
    end
    ea = '0; eb = '0; et = '0; em = '0;
    for (int i = 1; i < n_wm && i <= 11; i++) begin
      if (c == 3) begin
        if (i <= 3) et = {et[11:0], body_ch(seed, i)};
        else if (i <= 8) ea = {ea[23:0], body_ch(seed, i)};
      end else begin
        if (i <= 5) ea = {ea[23:0], body_ch(seed, i)};
        else if (i <= 10) eb = {eb[23:0], body_ch(seed, i)};
      end
    end
    ok_len = op_wm && n_wm <= 12 && len_ok(c, n_wm);
    if (ok_len && (c == 2 || c == 3)) em = body_ch(seed, n_wm - 1);
    erd  = !op_wm ? 16'(base) : 16'(base + lim);
    elen = (op_wm && n_wm <= 12) ? 4'(n_wm) : 4'd0;

    @(negedge clk); start = 1'b1; start_addr = 16'(base);
    @(negedge clk); start = 1'b0;
    k = 0;
    while (!done && k < 80) begin
      @(negedge clk);
      k++;
      if (inject && k == 3) begin start = 1'b1; start_addr = 16'(base + 50); end
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done === 1'b1, "R11 done pulse seen", 64'(done), 64'd1);
    chk(err_op === !op_wm, "R3 err_op", 64'(err_op), 64'(!op_wm));
    if (op_wm && n_wm > 12)
      chk(err_len === 1'b1, "R10 overrun err_len", 64'(err_len), 64'd1);
    else if (op_wm)
      chk(err_len === !ok_len, "R5 R9 err_len by class", 64'(err_len), 64'(!ok_len));
    chk(instr_len === elen, "R9 instr_len", 64'(instr_len), 64'(elen));
    chk(rd_addr === erd, "R4 rd_addr at end", 64'(rd_addr), 64'(erd));
    if (ok_len) exp_next = 16'(base + n_wm);
    chk(next_addr === exp_next, "R11 next_addr", 64'(next_addr), 64'(exp_next));
    if (ok_len) begin
      chk(op_code === opc, "R3 op_code", 64'(op_code), 64'(opc));
      if (c == 3) begin
        chk(io_ctl === et, "R7 io_ctl", 64'(io_ctl), 64'(et));
        chk(a_addr === ea, "R7 a_addr io", 64'(a_addr), 64'(ea));
        chk(b_addr === 30'd0, "R7 b_addr io", 64'(b_addr), 64'd0);
      end else begin
        chk(a_addr === ea, "R6 a_addr", 64'(a_addr), 64'(ea));
        chk(b_addr === eb, "R6 b_addr", 64'(b_addr), 64'(eb));
        chk(io_ctl === 18'd0, "R2 io_ctl cleared", 64'(io_ctl), 64'd0);
      end
      chk(modifier === em, "R8 modifier", 64'(modifier), 64'(em));
    end
    @(negedge clk);
    chk(done === 1'b0, "R11 done one cycle", 64'(done), 64'd0);
    chk(rd_en === 1'b0, "R2 idle after fetch", 64'(rd_en), 64'd0);
  endtask

  initial begin
    logic [5:0] ops [6];
    int n;
    ops[0] = 6'h31; ops[1] = 6'h12; ops[2] = 6'h32;
    ops[3] = 6'h24; ops[4] = 6'h29; ops[5] = 6'h05;
    for (int i = 0; i < 256; i++) begin mem_c[i] = '0; mem_w[i] = 1'b0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_en === 1'b0 && done === 1'b0, "R1 reset idle", 64'({rd_en, done}), 64'd0);
    chk(err_op === 1'b0 && err_len === 1'b0, "R1 reset errors", 64'({err_op, err_len}), 64'd0);
    chk(op_code === '0 && a_addr === '0 && b_addr === '0 && io_ctl === '0,
        "R1 reset fields", 64'(a_addr), 64'd0);
    chk(modifier === '0 && instr_len === '0 && next_addr === '0,
        "R1 reset len/next", 64'(next_addr), 64'd0);
    n = 0;
    for (int o = 0; o < 6; o++) begin
      for (int l = 1; l <= 13; l++) begin
        gap_mode = (l % 2 == 1);
        run(ops[o], 1'b1, l, n, (n * 23) % 200, (l == 10) && (o < 2));
        n++;
      end
    end
    for (int o = 0; o < 3; o++) begin
      gap_mode = (o == 1);
      run(ops[o], 1'b0, 6, n, (n * 23) % 200, 1'b0);
      n++;
    end
    // word mark inside an address field: length 3 on an add op is illegal
    gap_mode = 1'b0;
    run(6'h31, 1'b1, 3, n, 7, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule